// File: doc/BRIEF.md
# Segment Descriptor Address Translator

This block turns a protected-mode logical address into a linear address. A request carries a 16-bit selector and an offset. The selector's table-indicator bit chooses either the global descriptor table or the local descriptor table. The block then reads the 8-byte descriptor for that selector through a simple memory port. That port returns one byte on the cycle after each read strobe.

The block unpacks the descriptor into a base address, a segment limit and a 16-bit access field. It checks the offset against the limit. It then reports either base + offset or a fault code, with a one-cycle completion pulse.

Two further operations set up the tables. One writes the global table register directly. The other fills the local table register by fetching a descriptor from the global table. An optional one-entry cache holds the most recently fetched translation descriptor. A repeat access through the same table entry therefore needs no memory traffic. Privilege bits are not enforced. The access field is only passed through.

Top module: `seg_xlate`

## Requirements
- R1: After reset, req_ready is 1, and done and mem_rd_en are 0. Both table registers reset to base 0 and limit 0, so any translation before setup ends in a table-limit fault.
- R2: Selector layout: bits [15:3] are the table index, bit 2 is the table indicator (0 = global, 1 = local), and bits [1:0] are the requested privilege level. The privilege bits have no effect on the result.
- R3: Operation code 2 loads the global table register. req_off becomes the table base and req_sel becomes the table limit. It completes with fault 0, lin_valid 0 and no memory read.
- R4: An operation code of 0 (or 3) is a translation. With the table indicator at 0, the descriptor is read from address global_base + index*8.
- R5: With the table indicator at 1, a translation reads the descriptor from local_base + index*8, bounded by the local table limit.
- R6: Operation code 1 loads the local table register. It fetches the global-table entry that req_sel names and takes that entry's base and limit as the local table's base and limit. If req_sel has its table indicator set, the operation ends with fault code 3 and no memory read.
- R7: A descriptor is read as 8 bytes at consecutive addresses. The bytes are assembled little-endian: bytes 0–3 form the base, bytes 4–5 form the limit, and bytes 6–7 form the access field.
- R8: If index*8+7 exceeds the selected table's limit, the block reports fault code 1 and issues no memory read. An index whose last byte equals the limit is accepted.
- R9: An offset from 0 to limit inclusive yields lin_valid = 1 and lin_addr = base + offset. An offset above the limit yields fault code 2, lin_valid 0 and lin_addr 0.
- R10: done is high for exactly one cycle per request. When lin_valid is 1 at done, fault is 0 and acc_bits carries the descriptor's access field. Otherwise lin_addr and acc_bits are 0.
- R11: With the cache enabled, a translation through the same table indicator and index as the last fetched translation issues no memory read. Any load of either table register empties the cache.
- R12: A request is taken on a clock edge where req_valid and req_ready are both high. req_ready stays low from the next cycle until done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | 2 | 0/3 translate, 1 load local table, 2 load global table |
| req_sel | input | 16 | Selector, or table limit for operation 2 |
| req_off | input | 32 | Offset, or table base for operation 2 |
| mem_rd_en | output | 1 | Descriptor byte read strobe |
| mem_addr | output | 32 | Descriptor byte address |
| mem_rd_data | input | 8 | Byte read, valid the cycle after the strobe |
| done | output | 1 | One-cycle completion pulse |
| lin_valid | output | 1 | lin_addr holds a valid translation |
| lin_addr | output | 32 | Linear address |
| fault | output | 2 | 0 none, 1 table limit, 2 segment limit, 3 bad selector for local load |
| acc_bits | output | 16 | Access field of the descriptor used |

## Verification
The bench builds the block with CACHE_EN = 1. This lets it observe the cache's skipped memory reads and the cache being emptied when the global and local table registers are reloaded. A 1 KiB byte memory model is enough to hold a global table of eight entries and a small local table. With such short tables, an index whose last descriptor byte lands exactly on the limit, and the index one past it, are both easy to reach. Each completion is compared against a queued expectation that includes the number of memory reads. This makes a skipped read or an extra read as visible as a wrong address.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int ADDR_W     = 32;
  localparam int SEL_W      = 16;
  localparam int IDX_W      = 13;
  localparam int DESC_BYTES = 8;
  localparam int TAG_W      = IDX_W + 1;

  localparam logic [1:0] OP_XLATE   = 2'd0;
  localparam logic [1:0] OP_LD_LOC  = 2'd1;
  localparam logic [1:0] OP_LD_GLB  = 2'd2;

  localparam logic [1:0] FLT_NONE   = 2'd0;
  localparam logic [1:0] FLT_TABLE  = 2'd1;
  localparam logic [1:0] FLT_SEG    = 2'd2;
  localparam logic [1:0] FLT_SELECT = 2'd3;

  typedef struct packed {
    logic [31:0] base;
    logic [15:0] limit;
    logic [15:0] access;
  } desc_t;
endpackage

// File: rtl/seg_xlate_fetch.sv
module seg_xlate_fetch
  import seg_xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              fetch_done,
  output desc_t             fetch_desc
);
  localparam int IW = $clog2(DESC_BYTES);
  localparam logic [IW-1:0] LAST = IW'(DESC_BYTES - 1);

  logic [7:0]    bytes_q [DESC_BYTES];
  logic [IW-1:0] iss_idx_q;
  logic [IW-1:0] cap_idx_q;
  logic          cap_en_q;

  // Issue side: one strobe per byte on consecutive addresses.
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_rd_en <= 1'b0;
      mem_addr  <= '0;
      iss_idx_q <= '0;
    end else if (start) begin
      mem_rd_en <= 1'b1;
      mem_addr  <= start_addr;
      iss_idx_q <= '0;
    end else if (mem_rd_en) begin
      if (iss_idx_q == LAST) begin
        mem_rd_en <= 1'b0;
      end else begin
        iss_idx_q <= iss_idx_q + 1'b1;
        mem_addr  <= mem_addr + ADDR_W'(1);
      end
    end
  end

  // Capture side: data arrives one cycle after its strobe.
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_en_q   <= 1'b0;
      cap_idx_q  <= '0;
      fetch_done <= 1'b0;
    end else begin
      cap_en_q   <= mem_rd_en;
      cap_idx_q  <= iss_idx_q;
      fetch_done <= cap_en_q && (cap_idx_q == LAST);
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en_q) bytes_q[cap_idx_q] <= mem_rd_data;
  end

  assign fetch_desc.base   = {bytes_q[3], bytes_q[2], bytes_q[1], bytes_q[0]};
  assign fetch_desc.limit  = {bytes_q[5], bytes_q[4]};
  assign fetch_desc.access = {bytes_q[7], bytes_q[6]};

  assert_byte_walk_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && $past(mem_rd_en)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));
endmodule

// File: rtl/seg_xlate_cache.sv
module seg_xlate_cache
  import seg_xlate_pkg::*;
#(
  parameter bit EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             fill,
  input  logic [TAG_W-1:0] fill_tag,
  input  desc_t            fill_desc,
  input  logic [TAG_W-1:0] look_tag,
  output logic             hit,
  output desc_t            hit_desc
);
  generate
    if (EN) begin : g_cache
      logic             vld_q;
      logic [TAG_W-1:0] tag_q;
      desc_t            desc_q;

      always_ff @(posedge clk) begin
        if (rst || flush) begin
          vld_q <= 1'b0;
        end else if (fill) begin
          vld_q <= 1'b1;
        end
      end

      always_ff @(posedge clk) begin
        if (fill) begin
          tag_q  <= fill_tag;
          desc_q <= fill_desc;
        end
      end

      assign hit      = vld_q && (tag_q == look_tag);
      assign hit_desc = desc_q;

      assert_flush_empties_R11: assert property (@(posedge clk) disable iff (rst)
        flush |=> !hit);
    end else begin : g_nocache
      assign hit      = 1'b0;
      assign hit_desc = '0;
    end
  endgenerate
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter bit CACHE_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic [ADDR_W-1:0] req_off,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              done,
  output logic              lin_valid,
  output logic [ADDR_W-1:0] lin_addr,
  output logic [1:0]        fault,
  output logic [15:0]       acc_bits
);
  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_FETCH, S_RES} state_e;

  state_e            st_q;
  logic [1:0]        op_q;
  logic [SEL_W-1:0]  sel_q;
  logic [ADDR_W-1:0] off_q;
  logic [ADDR_W-1:0] gdt_base_q, ldt_base_q;
  logic [15:0]       gdt_lim_q, ldt_lim_q;
  desc_t             res_desc_q;

  logic [IDX_W-1:0]  idx;
  logic              ti;
  logic [ADDR_W-1:0] tbl_base, desc_addr;
  logic [15:0]       tbl_lim;
  logic              tbl_over, is_loc, is_glb, is_xl;
  logic              fetch_start, fetch_done, cache_fill, cache_flush, hit;
  desc_t             fetch_desc, hit_desc;

  assign idx       = sel_q[15:3];
  assign ti        = sel_q[2];
  assign is_loc    = (op_q == OP_LD_LOC);
  assign is_glb    = (op_q == OP_LD_GLB);
  assign is_xl     = !is_loc && !is_glb;
  assign tbl_base  = ti ? ldt_base_q : gdt_base_q;
  assign tbl_lim   = ti ? ldt_lim_q : gdt_lim_q;
  assign tbl_over  = {idx, 3'b111} > tbl_lim;
  assign desc_addr = tbl_base + {16'b0, idx, 3'b000};
  assign req_ready = (st_q == S_IDLE);

  assign fetch_start = (st_q == S_LOOK) && !is_glb && !(is_loc && ti)
                       && !tbl_over && !(is_xl && hit);
  assign cache_fill  = (st_q == S_FETCH) && fetch_done && is_xl;
  assign cache_flush = ((st_q == S_LOOK) && is_glb) || ((st_q == S_RES) && is_loc);

  seg_xlate_fetch u_fetch (
    .clk        (clk),
    .rst        (rst),
    .start      (fetch_start),
    .start_addr (desc_addr),
    .mem_rd_en  (mem_rd_en),
    .mem_addr   (mem_addr),
    .mem_rd_data(mem_rd_data),
    .fetch_done (fetch_done),
    .fetch_desc (fetch_desc)
  );

  seg_xlate_cache #(.EN(CACHE_EN)) u_cache (
    .clk      (clk),
    .rst      (rst),
    .flush    (cache_flush),
    .fill     (cache_fill),
    .fill_tag ({ti, idx}),
    .fill_desc(fetch_desc),
    .look_tag ({ti, idx}),
    .hit      (hit),
    .hit_desc (hit_desc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= S_IDLE;
      op_q       <= OP_XLATE;
      sel_q      <= '0;
      off_q      <= '0;
      gdt_base_q <= '0;
      gdt_lim_q  <= '0;
      ldt_base_q <= '0;
      ldt_lim_q  <= '0;
      res_desc_q <= '0;
      done       <= 1'b0;
      lin_valid  <= 1'b0;
      lin_addr   <= '0;
      fault      <= FLT_NONE;
      acc_bits   <= '0;
    end else begin
      done <= 1'b0;
      unique case (st_q)
        S_IDLE: if (req_valid) begin
          op_q  <= req_op;
          sel_q <= req_sel;
          off_q <= req_off;
          st_q  <= S_LOOK;
        end
        S_LOOK: begin
          if (is_glb || (is_loc && ti) || tbl_over) begin
            if (is_glb) begin
              gdt_base_q <= off_q;
              gdt_lim_q  <= sel_q;
            end
            done      <= 1'b1;
            lin_valid <= 1'b0;
            lin_addr  <= '0;
            acc_bits  <= '0;
            fault     <= is_glb ? FLT_NONE : (tbl_over && !is_loc) ? FLT_TABLE :
                         (is_loc && ti) ? FLT_SELECT : FLT_TABLE;
            st_q      <= S_IDLE;
          end else if (is_xl && hit) begin
            res_desc_q <= hit_desc;
            st_q       <= S_RES;
          end else begin
            st_q <= S_FETCH;
          end
        end
        S_FETCH: if (fetch_done) begin
          res_desc_q <= fetch_desc;
          st_q       <= S_RES;
        end
        S_RES: begin
          done <= 1'b1;
          st_q <= S_IDLE;
          if (is_loc) begin
            ldt_base_q <= res_desc_q.base;
            ldt_lim_q  <= res_desc_q.limit;
          end
          if (!is_loc && off_q <= {16'b0, res_desc_q.limit}) begin
            lin_valid <= 1'b1;
            lin_addr  <= res_desc_q.base + off_q;
            acc_bits  <= res_desc_q.access;
            fault     <= FLT_NONE;
          end else begin
            lin_valid <= 1'b0;
            lin_addr  <= '0;
            acc_bits  <= '0;
            fault     <= is_loc ? FLT_NONE : FLT_SEG;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assert_one_cycle_done_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_valid_means_clean_R10: assert property (@(posedge clk) disable iff (rst)
    (done && lin_valid) |-> (fault == FLT_NONE));
  assert_reads_only_fetching_R8: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> (st_q == S_FETCH));
  assert_busy_holds_ready_R12: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!req_ready && !done));
endmodule

// File: tb/seg_xlate_tb.sv
`timescale 1ns/1ps
module seg_xlate_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [15:0] req_sel = '0;
  logic [31:0] req_off = '0;
  logic        mem_rd_en;
  logic [31:0] mem_addr;
  logic [7:0]  mem_rd_data = '0;
  logic        done, lin_valid;
  logic [31:0] lin_addr;
  logic [1:0]  fault;
  logic [15:0] acc_bits;

  always #2 clk = ~clk;

  seg_xlate #(.CACHE_EN(1'b1)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_sel(req_sel), .req_off(req_off),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_data(mem_rd_data),
    .done(done), .lin_valid(lin_valid), .lin_addr(lin_addr),
    .fault(fault), .acc_bits(acc_bits)
  );

  logic [7:0] mem [0:1023];
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_addr[9:0]];

  typedef struct {
    logic [1:0]  flt;
    logic        vld;
    logic [31:0] lin;
    logic [15:0] acc;
    int          reads;
    string       req;
  } exp_t;

  exp_t q[$];
  int n_run = 0, n_fail = 0, rdcnt = 0;
  bit ended = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // Monitor: counts read strobes and compares each completion.
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_rd_en) rdcnt++;
      if (done) begin
        if (q.size() == 0) begin
          check(1'b0, "R10", "unexpected done", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(fault == e.flt, e.req, "fault", 32'(fault), 32'(e.flt));
          check(lin_valid == e.vld, e.req, "lin_valid", 32'(lin_valid), 32'(e.vld));
          check(lin_addr == e.lin, e.req, "lin_addr", lin_addr, e.lin);
          check(acc_bits == e.acc, e.req, "acc_bits", 32'(acc_bits), 32'(e.acc));
          check(rdcnt == e.reads, e.req, "read count", 32'(rdcnt), 32'(e.reads));
        end
        rdcnt = 0;
      end
    end
  end

  function automatic logic [15:0] mk(input int idx, input bit ti, input logic [1:0] rpl);
    return {idx[12:0], ti, rpl};
  endfunction

  task automatic put_desc(input int a, input logic [31:0] b, input logic [15:0] l,
                          input logic [15:0] ac);
    mem[a]   = b[7:0];   mem[a+1] = b[15:8];
    mem[a+2] = b[23:16]; mem[a+3] = b[31:24];
    mem[a+4] = l[7:0];   mem[a+5] = l[15:8];
    mem[a+6] = ac[7:0];  mem[a+7] = ac[15:8];
  endtask

  task automatic send(input logic [1:0] op, input logic [15:0] sel, input logic [31:0] off,
                      input logic [1:0] flt, input logic vld, input logic [31:0] lin,
                      input logic [15:0] acc, input int reads, input string req);
    exp_t e;
    e.flt = flt; e.vld = vld; e.lin = lin; e.acc = acc; e.reads = reads; e.req = req;
    q.push_back(e);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_sel = sel; req_off = off;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R12", "ready while busy", 32'(req_ready), 32'd0);
    while (q.size() != 0) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    put_desc(32'h108, 32'h1234_5678, 16'h0FFF, 16'h9A92);
    put_desc(32'h110, 32'h0000_0200, 16'h0017, 16'h0082);
    put_desc(32'h118, 32'h0000_8000, 16'h0000, 16'h4092);
    put_desc(32'h200, 32'hA000_0000, 16'h00FF, 16'h00F2);
    put_desc(32'h210, 32'h0000_0040, 16'hFFFF, 16'h1234);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "reset ready", 32'(req_ready), 32'd1);
    check(done == 1'b0, "R1", "reset done", 32'(done), 32'd0);
    check(mem_rd_en == 1'b0, "R1", "reset read", 32'(mem_rd_en), 32'd0);

    send(2'd0, mk(1,0,0), 32'h10, 2'd1, 0, 0, 0, 0, "R1");
    send(2'd2, 16'h003F, 32'h100, 2'd0, 0, 0, 0, 0, "R3");
    send(2'd0, mk(1,0,0), 32'h10, 2'd0, 1, 32'h1234_5688, 16'h9A92, 8, "R4");
    send(2'd0, mk(1,0,3), 32'h20, 2'd0, 1, 32'h1234_5698, 16'h9A92, 0, "R2");
    send(2'd0, mk(1,0,0), 32'hFFF, 2'd0, 1, 32'h1234_6677, 16'h9A92, 0, "R9");
    send(2'd0, mk(1,0,0), 32'h1000, 2'd2, 0, 0, 0, 0, "R9");
    send(2'd0, mk(8,0,0), 32'h0, 2'd1, 0, 0, 0, 0, "R8");
    send(2'd0, mk(7,0,0), 32'h0, 2'd0, 1, 32'h0, 16'h0, 8, "R8");
    send(2'd0, mk(0,1,0), 32'h0, 2'd1, 0, 0, 0, 0, "R5");
    send(2'd1, mk(2,1,0), 32'h0, 2'd3, 0, 0, 0, 0, "R6");
    send(2'd1, mk(2,0,0), 32'h0, 2'd0, 0, 0, 0, 8, "R6");
    send(2'd0, mk(0,1,0), 32'h80, 2'd0, 1, 32'hA000_0080, 16'h00F2, 8, "R5");
    send(2'd0, mk(2,1,1), 32'hFFFF, 2'd0, 1, 32'h0001_003F, 16'h1234, 8, "R7");
    send(2'd0, mk(3,1,0), 32'h0, 2'd1, 0, 0, 0, 0, "R8");
    send(2'd0, mk(3,0,0), 32'h0, 2'd0, 1, 32'h0000_8000, 16'h4092, 8, "R4");
    send(2'd0, mk(3,0,0), 32'h1, 2'd2, 0, 0, 0, 0, "R11");
    send(2'd2, 16'h003F, 32'h100, 2'd0, 0, 0, 0, 0, "R3");
    send(2'd0, mk(3,0,0), 32'h0, 2'd0, 1, 32'h0000_8000, 16'h4092, 8, "R11");
    repeat (3) @(negedge clk);
    if (!ended) begin
      ended = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL R12 watchdog: actual %h expected %h", 32'd0, 32'd1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule